// File: doc/BRIEF.md
# SPI Access Guard

This block watches every SPI access on the slave side and decides, when the select line is released, whether the access was clean. It works in the system clock domain on events that a front end has already decoded. These are a pulse for each serial clock edge that is counted, the MOSI value sampled on that edge, and a flag saying the access is a read. It also takes a flag marking bytes that belong to the data phase and the busy state of the internal fetch of the first read byte.

An access with a flaw raises a one-cycle error strobe, which also keeps register writes and side-effect functions from taking effect. The flaw is recorded as a four-bit cause code and bumps a saturating error counter. A clean access raises a one-cycle accept pulse instead, and the register file uses that pulse to commit staged writes. A status bit holds the outcome of the last evaluated access. While select is asserted and no serial clock has arrived yet, the block asks to drive that bit onto MISO, so a master can read the result of the previous access with a bare select pulse.

Top module: `spi_acc_guard`

## Requirements
- R1: An access is evaluated only when select is released and only if at least one clock edge was counted while select was high. Edges seen while select is low are ignored. `err_code_o` changes only on the clock edge that first samples select low, and the strobe or accept pulse is visible in the cycle after that edge.
- R2: If the number of counted edges is not a multiple of 8, bit 0 of the cause code is set.
- R3: For a read, an edge counted while `fetch_busy_i` is high sets bit 1 of the cause code.
- R4: A termination byte is a completed data-phase byte whose 8 MOSI samples are all 1. A read with no termination byte sets bit 2 of the cause code.
- R5: A read in which a data-phase byte completes after the termination byte sets bit 3 of the cause code.
- R6: An evaluated access with any cause bit set gives `err_strobe_o` for one cycle. An evaluated access with no cause bit set gives `acc_ok_o` for one cycle. The two never coincide. `err_code_o` is loaded with the causes, or with 0 for a clean access.
- R7: `err_cnt_o` (8 bits) increases by one for each erroneous access, stays at 255 once it is reached, and changes at no other time.
- R8: `status_o` is 1 exactly when `err_code_o` is 0. `miso_oe_o` is high while select is high, no edge has yet been counted in this access and `flag_en_i` is high. While `miso_oe_o` is high, `miso_o` equals `status_o`.
- R9: With `flag_en_i` low, `miso_oe_o` stays low. This setting is for the modes in which the flag cannot be presented.
- R10: A select window with no counted edge produces no pulse and leaves code, counter and status unchanged.
- R11: After reset the counter and code are 0, status is 1, and both pulses and `miso_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Slave select, high while the access is running |
| sclk_edge_i | input | 1 | One-cycle pulse per counted serial clock edge |
| mosi_i | input | 1 | MOSI value sampled on that edge |
| rd_acc_i | input | 1 | Access is a read (sampled at any time during select) |
| data_phase_i | input | 1 | Current byte belongs to the data phase |
| fetch_busy_i | input | 1 | First read byte is still being fetched |
| flag_en_i | input | 1 | Status flag may be presented in the current SPI mode |
| err_strobe_o | output | 1 | One-cycle pulse: erroneous access, block register writes |
| acc_ok_o | output | 1 | One-cycle pulse: clean access, commit register writes |
| err_cnt_o | output | 8 | Saturating error counter |
| err_code_o | output | 4 | Cause bits of the last evaluated access |
| status_o | output | 1 | 1 when the last evaluated access was clean |
| miso_oe_o | output | 1 | Request to drive the status flag onto MISO |
| miso_o | output | 1 | Flag value for MISO |

## Verification
The bench aims at reads that stop one byte early, reads that run one byte past the termination byte, and an access that trails a few loose bits. A design that misjudged any of these would report the wrong cause bit, or accept an access it should reject. A bare select pulse with no clock must leave the status untouched, or a probe would wipe out the very result it tries to read. The bench also drives the counter past 255, where a wrapping counter would fall back to zero. It checks that the MISO flag vanishes at the first edge, where a late turn-off would corrupt the first bit the master sends.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;
  localparam int CAUSE_N = 4;

  // cause bits, MSB first: extra byte, missing termination, busy clock, partial byte
  typedef struct packed {
    logic extra;
    logic noterm;
    logic busy;
    logic part;
  } cause_t;
endpackage

// File: rtl/spi_guard_track.sv
module spi_guard_track
  import spi_guard_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_i,
  input  logic   edge_i,
  input  logic   mosi_i,
  input  logic   rd_i,
  input  logic   data_i,
  input  logic   busy_i,
  output logic   end_o,
  output logic   clocked_o,
  output cause_t cause_o
);
  localparam int BW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BYTE_BITS - 1);

  logic          sel_q, sel_n;
  logic          clocked_q, clocked_n;
  logic          rd_q, rd_n;
  logic [BW-1:0] bit_q, bit_n;
  logic          ones_q, ones_n;
  logic          term_q, term_n;
  logic          busy_q, busy_n;
  logic          extra_q, extra_n;

  logic take;
  logic last_bit;
  logic ones_cur;
  logic rd_eff;

  always_comb begin
    take     = sel_i & edge_i;
    last_bit = (bit_q == LAST);
    ones_cur = ((bit_q == '0) ? 1'b1 : ones_q) & mosi_i;
    rd_eff   = rd_q | rd_i;

    sel_n     = sel_i;
    clocked_n = clocked_q;
    rd_n      = rd_q;
    bit_n     = bit_q;
    ones_n    = ones_q;
    term_n    = term_q;
    busy_n    = busy_q;
    extra_n   = extra_q;

    if (!sel_i) begin
      clocked_n = 1'b0;
      rd_n      = 1'b0;
      bit_n     = '0;
      ones_n    = 1'b0;
      term_n    = 1'b0;
      busy_n    = 1'b0;
      extra_n   = 1'b0;
    end else begin
      rd_n = rd_eff;
      if (take) begin
        clocked_n = 1'b1;
        ones_n    = ones_cur;
        bit_n     = last_bit ? '0 : bit_q + 1'b1;
        if (rd_eff && busy_i) begin
          busy_n = 1'b1;
        end
        if (last_bit && data_i && rd_eff) begin
          if (term_q) begin
            extra_n = 1'b1;
          end
          if (ones_cur) begin
            term_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      clocked_q <= 1'b0;
      rd_q      <= 1'b0;
      bit_q     <= '0;
      ones_q    <= 1'b0;
      term_q    <= 1'b0;
      busy_q    <= 1'b0;
      extra_q   <= 1'b0;
    end else begin
      sel_q     <= sel_n;
      clocked_q <= clocked_n;
      rd_q      <= rd_n;
      bit_q     <= bit_n;
      ones_q    <= ones_n;
      term_q    <= term_n;
      busy_q    <= busy_n;
      extra_q   <= extra_n;
    end
  end

  always_comb begin
    end_o          = sel_q & ~sel_i & clocked_q;
    clocked_o      = clocked_q;
    cause_o.part   = (bit_q != '0);
    cause_o.busy   = busy_q;
    cause_o.noterm = rd_q & ~term_q;
    cause_o.extra  = extra_q;
  end
endmodule

// File: rtl/spi_guard_log.sv
module spi_guard_log
  import spi_guard_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               end_i,
  input  cause_t             cause_i,
  output logic               strobe_o,
  output logic               ok_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CAUSE_N-1:0] code_o,
  output logic               status_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic               strobe_q, strobe_n;
  logic               ok_q, ok_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [CAUSE_N-1:0] code_q, code_n;
  logic               stat_q, stat_n;
  logic               bad;

  always_comb begin
    bad      = |cause_i;
    strobe_n = 1'b0;
    ok_n     = 1'b0;
    cnt_n    = cnt_q;
    code_n   = code_q;
    stat_n   = stat_q;
    if (end_i) begin
      strobe_n = bad;
      ok_n     = ~bad;
      code_n   = cause_i;
      stat_n   = ~bad;
      if (bad && (cnt_q != CNT_MAX)) begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      ok_q     <= 1'b0;
      cnt_q    <= '0;
      code_q   <= '0;
      stat_q   <= 1'b1;
    end else begin
      strobe_q <= strobe_n;
      ok_q     <= ok_n;
      cnt_q    <= cnt_n;
      code_q   <= code_n;
      stat_q   <= stat_n;
    end
  end

  assign strobe_o = strobe_q;
  assign ok_o     = ok_q;
  assign cnt_o    = cnt_q;
  assign code_o   = code_q;
  assign status_o = stat_q;
endmodule

// File: rtl/spi_guard_flag.sv
module spi_guard_flag (
  input  logic sel_i,
  input  logic edge_i,
  input  logic clocked_i,
  input  logic en_i,
  input  logic status_i,
  output logic oe_o,
  output logic miso_o
);
  always_comb begin
    oe_o   = sel_i & ~clocked_i & ~edge_i & en_i;
    miso_o = status_i;
  end
endmodule

// File: rtl/spi_acc_guard.sv
module spi_acc_guard
  import spi_guard_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               sclk_edge_i,
  input  logic               mosi_i,
  input  logic               rd_acc_i,
  input  logic               data_phase_i,
  input  logic               fetch_busy_i,
  input  logic               flag_en_i,
  output logic               err_strobe_o,
  output logic               acc_ok_o,
  output logic [CNT_W-1:0]   err_cnt_o,
  output logic [CAUSE_N-1:0] err_code_o,
  output logic               status_o,
  output logic               miso_oe_o,
  output logic               miso_o
);
  logic [1:0] rst_q;
  logic       rst_sync_n;
  logic       acc_end;
  logic       clocked;
  cause_t     cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_q[1];

  spi_guard_track #(.BYTE_BITS(BYTE_BITS)) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_i     (sel_i),
    .edge_i    (sclk_edge_i),
    .mosi_i    (mosi_i),
    .rd_i      (rd_acc_i),
    .data_i    (data_phase_i),
    .busy_i    (fetch_busy_i),
    .end_o     (acc_end),
    .clocked_o (clocked),
    .cause_o   (cause)
  );

  spi_guard_log #(.CNT_W(CNT_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .end_i    (acc_end),
    .cause_i  (cause),
    .strobe_o (err_strobe_o),
    .ok_o     (acc_ok_o),
    .cnt_o    (err_cnt_o),
    .code_o   (err_code_o),
    .status_o (status_o)
  );

  spi_guard_flag u_flag (
    .sel_i     (sel_i),
    .edge_i    (sclk_edge_i),
    .clocked_i (clocked),
    .en_i      (flag_en_i),
    .status_i  (status_o),
    .oe_o      (miso_oe_o),
    .miso_o    (miso_o)
  );
endmodule

// File: rtl/spi_acc_guard_chk.sv
module spi_acc_guard_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_i,
  input logic             sclk_edge_i,
  input logic             flag_en_i,
  input logic             err_strobe_o,
  input logic             acc_ok_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic [3:0]       err_code_o,
  input logic             status_o,
  input logic             miso_oe_o,
  input logic             miso_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_PULSE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strobe_o || acc_ok_o) |-> $past(!sel_i)); // R1
  AST_CODE_HOLD_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_i) |-> $stable(err_code_o)); // R1
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_strobe_o && acc_ok_o)); // R6
  AST_OK_CLEAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok_o |-> (err_code_o == 4'h0)); // R6
  AST_BAD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe_o |-> (err_code_o != 4'h0)); // R6
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o == CMAX) |=> (err_cnt_o == CMAX)); // R7
  AST_CNT_ONLY_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !err_strobe_o |-> $stable(err_cnt_o)); // R7
  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    status_o == (err_code_o == 4'h0)); // R8
  AST_FLAG_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> (sel_i && flag_en_i)); // R8
  AST_FLAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> (miso_o == status_o)); // R8
  AST_FLAG_GONE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && sclk_edge_i) |=> !miso_oe_o); // R8
  AST_FLAG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en_i |-> !miso_oe_o); // R9
endmodule

bind spi_acc_guard spi_acc_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_i        (sel_i),
  .sclk_edge_i  (sclk_edge_i),
  .flag_en_i    (flag_en_i),
  .err_strobe_o (err_strobe_o),
  .acc_ok_o     (acc_ok_o),
  .err_cnt_o    (err_cnt_o),
  .err_code_o   (err_code_o),
  .status_o     (status_o),
  .miso_oe_o    (miso_oe_o),
  .miso_o       (miso_o)
);

// File: tb/sim_spi_acc_guard.sv
module sim_spi_acc_guard;
  typedef struct {
    logic [3:0] code;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, sedge, mosi, rd, dphase, fbusy, fen;
  logic       err_strobe, acc_ok, status, moe, mbit;
  logic [7:0] cnt;
  logic [3:0] code;

  int         total = 0;
  int         bad = 0;
  int         exp_cnt = 0;
  logic       exp_status = 1'b1;
  logic [3:0] exp_code = 4'h0;
  logic       mon_on = 1'b0;
  exp_t       expq[$];

  always #5 clk = ~clk;

  spi_acc_guard u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_edge_i(sedge), .mosi_i(mosi),
    .rd_acc_i(rd), .data_phase_i(dphase), .fetch_busy_i(fbusy), .flag_en_i(fen),
    .err_strobe_o(err_strobe), .acc_ok_o(acc_ok), .err_cnt_o(cnt),
    .err_code_o(code), .status_o(status), .miso_oe_o(moe), .miso_o(mbit)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_val(input int i, input int term_at, input bit more_ff);
    if (i < 2) return 8'h5A;
    if (i == term_at) return 8'hFF;
    if (term_at >= 0 && i > term_at && more_ff) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic bit_out(input logic b, input logic bz);
    @(negedge clk);
    sedge = 1'b1; mosi = b; fbusy = bz;
    @(negedge clk);
    sedge = 1'b0; fbusy = 1'b0;
  endtask

  // driver: computes the expected verdict and queues it for the monitor
  task automatic access(input bit is_rd, input int nbytes, input int tail,
                        input int term_at, input bit more_ff, input bit busy_req,
                        input string rq);
    exp_t e;
    bit   term = 0;
    bit   extra = 0;
    logic [7:0] v;
    for (int i = 2; i < nbytes; i++) begin
      if (term) extra = 1;
      if (byte_val(i, term_at, more_ff) == 8'hFF) term = 1;
    end
    e.code = {is_rd & extra, is_rd & ~term, is_rd & busy_req, tail % 8 != 0};
    e.tag  = rq;
    expq.push_back(e);

    @(negedge clk);
    sel = 1'b1; rd = is_rd;
    @(negedge clk);
    chk(moe == 1'b1, "R8", "flag drive before first edge", moe, 1);
    chk(mbit == exp_status, "R8", "flag value", mbit, exp_status);
    for (int i = 0; i < nbytes; i++) begin
      v = byte_val(i, term_at, more_ff);
      dphase = (i >= 2);
      for (int b = 7; b >= 0; b--) begin
        bit_out(v[b], busy_req && i == 0 && b == 7);
        if (i == 0 && b == 7)
          chk(moe == 1'b0, "R8", "flag drive after first edge", moe, 0);
      end
    end
    dphase = (nbytes >= 2);
    for (int t = 0; t < tail; t++) bit_out(1'b0, 1'b0);
    @(negedge clk);
    sel = 1'b0; rd = 1'b0; dphase = 1'b0;
    repeat (4) @(negedge clk);
    if (e.code != 0 && exp_cnt < 255) exp_cnt++;
    exp_status = (e.code == 0);
    exp_code   = e.code;
    chk(cnt == 8'(exp_cnt), "R7", "error counter", cnt, exp_cnt);
    chk(status == exp_status, "R8", "status bit", status, exp_status);
  endtask

  // monitor: pops the expected verdict when the design produces one
  always @(negedge clk) begin
    if (mon_on && (err_strobe || acc_ok)) begin
      if (expq.size() == 0) begin
        chk(0, "R10", "pulse without evaluated access", {err_strobe, acc_ok}, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(!(err_strobe && acc_ok), "R6", "both pulses", {err_strobe, acc_ok}, 1);
        chk(err_strobe == (e.code != 0), {"R6 ", e.tag}, "strobe", err_strobe, e.code != 0);
        chk(code == e.code, e.tag, "cause code", code, e.code);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", "run did not end", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 0; sedge = 0; mosi = 0; rd = 0; dphase = 0; fbusy = 0; fen = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(cnt == 0, "R11", "counter", cnt, 0);
    chk(code == 0, "R11", "code", code, 0);
    chk(status == 1, "R11", "status", status, 1);
    chk(!err_strobe && !acc_ok && !moe, "R11", "pulses/flag", {err_strobe, acc_ok, moe}, 0);
    mon_on = 1'b1;

    access(0, 3, 0, -1, 0, 0, "R6");        // clean write
    access(0, 2, 3, -1, 0, 0, "R2");        // loose bits
    access(1, 4, 0, 3, 0, 0, "R4");         // clean read, terminated on last byte
    access(1, 4, 0, 3, 0, 1, "R3");         // clock while fetching
    access(1, 4, 0, -1, 0, 0, "R4");        // never terminated
    access(1, 5, 0, 3, 0, 0, "R5");         // one byte past termination (low)
    access(1, 5, 0, 3, 1, 0, "R5");         // one byte past termination (high)
    access(1, 3, 5, -1, 0, 1, "R2");        // several causes at once

    // R10 bare select probe: flag readable, nothing evaluated
    @(negedge clk); sel = 1'b1; rd = 1'b1;
    repeat (2) @(negedge clk);
    chk(moe == 1'b1, "R10", "probe flag drive", moe, 1);
    chk(mbit == exp_status, "R10", "probe flag value", mbit, exp_status);
    sel = 1'b0; rd = 1'b0;
    repeat (4) @(negedge clk);
    chk(code == exp_code, "R10", "code after probe", code, exp_code);
    chk(cnt == 8'(exp_cnt), "R10", "counter after probe", cnt, exp_cnt);

    // R9 flag withheld
    fen = 1'b0;
    @(negedge clk); sel = 1'b1;
    repeat (2) @(negedge clk);
    chk(moe == 1'b0, "R9", "flag with enable low", moe, 0);
    sel = 1'b0;
    repeat (2) @(negedge clk);
    fen = 1'b1;

    // R1 edges outside select are ignored
    for (int k = 0; k < 3; k++) bit_out(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(code == exp_code, "R1", "code after idle edges", code, exp_code);
    access(0, 2, 0, -1, 0, 0, "R1");

    // R7 saturation
    for (int k = 0; k < 260; k++) access(0, 1, 1, -1, 0, 0, "R7");
    chk(cnt == 8'hFF, "R7", "saturated counter", cnt, 255);
    access(0, 2, 0, -1, 0, 0, "R7");
    chk(expq.size() == 0, "R6", "verdicts outstanding", expq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule